// File: doc/BRIEF.md
# Serial Flash Erase and Program Command Engine

This block is the device-side front end of a page-organised serial flash. While chip select is held low it shifts in a 32-bit command frame over SPI mode 0. It samples the data line on each rising edge of the serial clock, most significant bit first. When chip select returns high after exactly 32 bits, it decodes the frame. If the opcode is one it knows, it launches one self-timed operation:

- a program of one page from one of two holding buffers, with no built-in erase;
- an erase of a single page;
- an erase of an aligned group of eight pages.

The SPI pins are asynchronous to the system clock. Each of them passes through a two-flop synchroniser before any edge detection. The storage array itself sits outside this block. It receives a one-cycle request strobe together with the operation kind, the buffer select and the first target page. The array applies the expected data rule: an erase sets bits to 1, and a program stores the old value AND the new value. The block holds `busy` high for a parameterised number of system-clock cycles, one count for each operation kind. Frames that arrive during that time are dropped.

Top module: `sflash_cmd_engine`

## Requirements
- R1: After reset, `busy` and `op_valid` are low, and no operation starts until a complete frame has been received.
- R2: Frame layout, in shift order: an 8-bit opcode in frame bits 31:24, then a reserved bit 23 that has no effect, then the address field. Bits are captured on the rising edge of the serial clock, most significant first.
- R3: Opcode 88h launches a page program with `op_kind`=0 and `op_buf`=0. Opcode 89h does the same with `op_buf`=1. In both cases `op_addr` is frame bits 22:10, and frame bits 9:0 have no effect.
- R4: Opcode 81h launches a single-page erase with `op_kind`=1, `op_buf`=0 and `op_addr` equal to frame bits 22:10.
- R5: Opcode 50h launches an eight-page erase with `op_kind`=2 and `op_buf`=0. The block number is frame bits 22:13, and `op_addr` is that number times 8, so its low three bits are 0. Frame bits 12:0 have no effect.
- R6: An operation is launched only when chip select rises after exactly 32 serial-clock rising edges. If chip select rises after fewer or more edges, nothing starts.
- R7: A frame whose opcode is not 88h, 89h, 81h or 50h starts nothing.
- R8: `op_valid` is a one-cycle pulse, and `busy` rises in the same cycle as that pulse.
- R9: `busy` stays high for exactly `T_PROG` cycles after a program, `T_PAGE_ERASE` cycles after a page erase, and `T_BLOCK_ERASE` cycles after a block erase.
- R10: A frame that completes while `busy` is high is dropped. It produces no pulse and does not extend `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock, mode 0, asynchronous |
| spi_cs_n | input | 1 | Chip select, active low, asynchronous |
| spi_mosi | input | 1 | Serial data in |
| op_valid | output | 1 | One-cycle operation request strobe |
| op_kind | output | 2 | 0 program, 1 page erase, 2 block erase |
| op_buf | output | 1 | Source buffer for a program |
| op_addr | output | 13 | First target page |
| busy | output | 1 | Operation in progress |

## Verification
Each of the four legal opcodes is sent with address fields that are all ones, all zeros or mixed. This shows that the address comes from the right bit range and that the two program opcodes differ only in the buffer select. The reserved and don't-care bits are driven to non-zero values, and a correct decode shows they are ignored. For block erase, the low page bits are filled with junk, and the checks confirm the address still comes out aligned to eight pages. The discard paths are tried with:

- frames of 31 and 33 bits;
- a chip-select pulse with no clocks;
- opcodes that are close to a legal one but not equal to it;
- a complete frame sent while a long erase is running.

For every frame that starts an operation, the busy width is counted, which tells apart the three duration parameters.

// File: rtl/sfc_pkg.sv
// Shared definitions for the serial flash command engine.
package sfc_pkg;
    localparam int FRAME_BITS = 32;
    localparam int PAGE_BITS  = 13;
    localparam int BLOCK_SPAN = 3;   // log2 of pages per block

    typedef enum logic [1:0] {
        OP_PROG   = 2'd0,
        OP_PERASE = 2'd1,
        OP_BERASE = 2'd2
    } op_kind_e;

    localparam logic [7:0] OPC_PROG_B0 = 8'h88;
    localparam logic [7:0] OPC_PROG_B1 = 8'h89;
    localparam logic [7:0] OPC_PERASE  = 8'h81;
    localparam logic [7:0] OPC_BERASE  = 8'h50;
endpackage

// File: rtl/sfc_sync.sv
// Two-flop synchroniser bank.
// Assumes each bit is independent; RST_VAL gives the idle level per bit.
module sfc_sync #(
    parameter int              W       = 1,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] meta;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Two-stage capture of one asynchronous bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta[i]   <= RST_VAL[i];
                q_sync[i] <= RST_VAL[i];
            end else begin
                meta[i]   <= d_async[i];
                q_sync[i] <= meta[i];
            end
        end
    end
endmodule

// File: rtl/sfc_shift.sv
// Frame receiver: samples data on rising serial clock while select is low,
// counts bits (saturating one past a full frame) and flags the select
// rising edge when exactly a full frame was captured.
// Assumes all inputs are already synchronised to clk.
module sfc_shift #(
    parameter int FRAME_BITS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sck_s,
    input  logic                  cs_n_s,
    input  logic                  mosi_s,
    output logic [FRAME_BITS-1:0] frame,
    output logic                  frame_end
);
    localparam int CNT_W = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] OVER = CNT_W'(FRAME_BITS + 1);

    logic             sck_q, cs_q;
    logic [CNT_W-1:0] nbits;
    logic             sck_rise, cs_rise;

    assign sck_rise  = sck_s && !sck_q;
    assign cs_rise   = cs_n_s && !cs_q;
    assign frame_end = cs_rise && (nbits == FULL);

    // Remember previous levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck_s;
            cs_q  <= cs_n_s;
        end
    end

    // Shift data and count bits; counter clears while deselected
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame <= '0;
            nbits <= '0;
        end else if (cs_n_s) begin
            nbits <= '0;
        end else if (sck_rise) begin
            frame <= {frame[FRAME_BITS-2:0], mosi_s};
            if (nbits != OVER) nbits <= nbits + 1'b1;
        end
    end
endmodule

// File: rtl/sfc_decode.sv
// Combinational opcode and address decode of a captured frame.
// Assumes frame[31:24] opcode, bit 23 reserved, address field from bit 22.
module sfc_decode
    import sfc_pkg::*;
(
    input  logic [FRAME_BITS-1:0] frame,
    output logic                  legal,
    output logic [1:0]            kind,
    output logic                  bsel,
    output logic [PAGE_BITS-1:0]  page
);
    localparam int ATOP = FRAME_BITS - 10;           // bit 22
    localparam int ABOT = ATOP - PAGE_BITS + 1;      // bit 10
    localparam int BBOT = ABOT + BLOCK_SPAN;         // bit 13

    logic [7:0] opc;
    logic       unused_bits;

    assign opc         = frame[FRAME_BITS-1 -: 8];
    assign unused_bits = ^{frame[FRAME_BITS-9], frame[ABOT-1:0]};

    // Map opcode to operation kind, buffer and target page
    always_comb begin
        legal = 1'b1;
        kind  = OP_PROG;
        bsel  = 1'b0;
        page  = frame[ATOP:ABOT];
        unique case (opc)
            OPC_PROG_B0: bsel = 1'b0;
            OPC_PROG_B1: bsel = 1'b1;
            OPC_PERASE:  kind = OP_PERASE;
            OPC_BERASE: begin
                kind = OP_BERASE;
                page = {frame[ATOP:BBOT], {BLOCK_SPAN{1'b0}}};
            end
            default:     legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/sfc_timer.sv
// Self-timed operation counter: loads a per-kind duration on start and
// holds busy for exactly that many cycles.
// Assumes start is only raised while busy is low; all durations >= 1.
module sfc_timer
    import sfc_pkg::*;
#(
    parameter int T_PROG        = 300,
    parameter int T_PAGE_ERASE  = 200,
    parameter int T_BLOCK_ERASE = 500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] kind,
    output logic       busy
);
    localparam int TMAX1 = (T_PROG > T_PAGE_ERASE) ? T_PROG : T_PAGE_ERASE;
    localparam int TMAX  = (TMAX1 > T_BLOCK_ERASE) ? TMAX1 : T_BLOCK_ERASE;
    localparam int CW    = $clog2(TMAX + 1);

    logic [CW-1:0] remain;
    logic [CW-1:0] load_val;

    // Pick the reload value for the requested kind
    always_comb begin
        unique case (kind)
            OP_PERASE: load_val = CW'(T_PAGE_ERASE - 1);
            OP_BERASE: load_val = CW'(T_BLOCK_ERASE - 1);
            default:   load_val = CW'(T_PROG - 1);
        endcase
    end

    // Down-count while busy, release at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            remain <= load_val;
        end else if (busy) begin
            if (remain == '0) busy <= 1'b0;
            else              remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/sflash_cmd_engine.sv
// Top of the serial flash erase/program command engine. Synchronises the
// SPI pins, captures a frame, decodes it on select release and launches a
// self-timed operation towards the array.
// Assumes SPI mode 0 with serial clock well below clk/4.
module sflash_cmd_engine
    import sfc_pkg::*;
#(
    parameter int T_PROG        = 300,
    parameter int T_PAGE_ERASE  = 200,
    parameter int T_BLOCK_ERASE = 500
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 spi_sck,
    input  logic                 spi_cs_n,
    input  logic                 spi_mosi,
    output logic                 op_valid,
    output logic [1:0]           op_kind,
    output logic                 op_buf,
    output logic [PAGE_BITS-1:0] op_addr,
    output logic                 busy
);
    logic [2:0]            pins_s;
    logic [FRAME_BITS-1:0] frame;
    logic                  frame_end;
    logic                  legal, bsel, launch;
    logic [1:0]            kind;
    logic [PAGE_BITS-1:0]  page;

    sfc_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({spi_sck, spi_cs_n, spi_mosi}),
        .q_sync  (pins_s)
    );

    sfc_shift #(.FRAME_BITS(FRAME_BITS)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_s     (pins_s[2]),
        .cs_n_s    (pins_s[1]),
        .mosi_s    (pins_s[0]),
        .frame     (frame),
        .frame_end (frame_end)
    );

    sfc_decode u_dec (
        .frame (frame),
        .legal (legal),
        .kind  (kind),
        .bsel  (bsel),
        .page  (page)
    );

    assign launch = frame_end && legal && !busy;

    sfc_timer #(
        .T_PROG        (T_PROG),
        .T_PAGE_ERASE  (T_PAGE_ERASE),
        .T_BLOCK_ERASE (T_BLOCK_ERASE)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (launch),
        .kind  (kind),
        .busy  (busy)
    );

    // Register the request towards the array
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_valid <= 1'b0;
            op_kind  <= OP_PROG;
            op_buf   <= 1'b0;
            op_addr  <= '0;
        end else begin
            op_valid <= launch;
            if (launch) begin
                op_kind <= kind;
                op_buf  <= bsel;
                op_addr <= page;
            end
        end
    end
endmodule

// File: rtl/sfc_engine_chk.sv
// Property checker for the command engine, attached by bind.
module sfc_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [1:0]  op_kind,
    input logic [12:0] op_addr,
    input logic        busy
);
    // R8
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> !op_valid);

    // R8
    busy_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> op_valid);

    // R8
    req_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> busy);

    // R10
    idle_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> !$past(busy));

    // R5
    block_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'd2) |-> (op_addr[2:0] == 3'b000));

    // R7
    kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> (op_kind != 2'd3));
endmodule

bind sflash_cmd_engine sfc_engine_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_kind  (op_kind),
    .op_addr  (op_addr),
    .busy     (busy)
);

// File: tb/sflash_cmd_engine_test.sv
module sflash_cmd_engine_test;
    localparam int TP = 300, TPE = 200, TBE = 500;
    localparam int HALF = 4;

    typedef struct packed {
        logic [31:0] frame;
        logic [5:0]  nbits;
        logic        start;
        logic [1:0]  kind;
        logic        bsel;
        logic [12:0] addr;
        logic [15:0] dur;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{ {8'h88,1'b0,13'h1ABC,10'h000}, 6'd32, 1'b1, 2'd0, 1'b0, 13'h1ABC, 16'(TP)  },  // R3
        '{ {8'h89,1'b1,13'h0005,10'h2AA}, 6'd32, 1'b1, 2'd0, 1'b1, 13'h0005, 16'(TP)  },  // R3 R2
        '{ {8'h81,1'b0,13'h1FFF,10'h3FF}, 6'd32, 1'b1, 2'd1, 1'b0, 13'h1FFF, 16'(TPE) },  // R4
        '{ {8'h50,1'b0,10'h3FF,13'h1FFF}, 6'd32, 1'b1, 2'd2, 1'b0, 13'h1FF8, 16'(TBE) },  // R5
        '{ {8'h50,1'b1,10'h001,13'h0A5A}, 6'd32, 1'b1, 2'd2, 1'b0, 13'h0008, 16'(TBE) },  // R5
        '{ {8'h89,1'b0,13'h0000,10'h000}, 6'd32, 1'b1, 2'd0, 1'b1, 13'h0000, 16'(TP)  },  // R3
        '{ {8'h81,1'b0,13'h0A55,10'h155}, 6'd32, 1'b1, 2'd1, 1'b0, 13'h0A55, 16'(TPE) },  // R4
        '{ {8'h82,1'b0,13'h0123,10'h000}, 6'd32, 1'b0, 2'd0, 1'b0, 13'h0000, 16'd0    },  // R7
        '{ {8'h51,1'b0,13'h0123,10'h000}, 6'd32, 1'b0, 2'd0, 1'b0, 13'h0000, 16'd0    },  // R7
        '{ {8'h88,1'b0,13'h0123,10'h000}, 6'd31, 1'b0, 2'd0, 1'b0, 13'h0000, 16'd0    },  // R6
        '{ {8'h88,1'b0,13'h0123,10'h000}, 6'd33, 1'b0, 2'd0, 1'b0, 13'h0000, 16'd0    }   // R6
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic        op_valid, op_buf, busy;
    logic [1:0]  op_kind;
    logic [12:0] op_addr;

    int checks = 0, fails = 0;
    int pulses = 0, run = 0, last_len = 0;
    logic [1:0]  cap_kind;
    logic        cap_buf;
    logic [12:0] cap_addr;

    always #4 clk = ~clk;   // 125 MHz

    sflash_cmd_engine #(.T_PROG(TP), .T_PAGE_ERASE(TPE), .T_BLOCK_ERASE(TBE)) uut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .op_valid(op_valid), .op_kind(op_kind), .op_buf(op_buf),
        .op_addr(op_addr), .busy(busy)
    );

    // Observe outputs away from the active edge
    always @(negedge clk) begin
        if (op_valid) begin
            pulses   <= pulses + 1;
            cap_kind <= op_kind;
            cap_buf  <= op_buf;
            cap_addr <= op_addr;
        end
        if (busy) run <= run + 1;
        else if (run != 0) begin
            last_len <= run;
            run <= 0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] fr, input int n);
        cs_n = 1'b0;
        repeat (HALF) @(posedge clk);
        for (int i = 0; i < n; i++) begin
            mosi = (i < 32) ? fr[31-i] : 1'b0;
            repeat (HALF) @(posedge clk);
            sck = 1'b1;
            repeat (HALF) @(posedge clk);
            sck = 1'b0;
        end
        repeat (HALF) @(posedge clk);
        cs_n = 1'b1;
    endtask

    task automatic wait_idle();
        int guard = 0;
        @(negedge clk);
        while (busy && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int p0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(op_valid == 1'b0, "R1 op_valid", op_valid, 0);
        rst_n = 1'b1;
        repeat (20) @(posedge clk);
        @(negedge clk);
        check(pulses == 0 && !busy, "R1 idle after reset", pulses, 0);

        for (int v = 0; v < NV; v++) begin
            p0 = pulses;
            send(VECS[v].frame, int'(VECS[v].nbits));
            repeat (10) @(negedge clk);
            check(pulses - p0 == int'(VECS[v].start), "R6 start count", pulses - p0, VECS[v].start);
            if (VECS[v].start) begin
                check(cap_kind == VECS[v].kind, "R2 op_kind", cap_kind, VECS[v].kind);
                check(cap_buf == VECS[v].bsel, "R3 op_buf", cap_buf, VECS[v].bsel);
                check(cap_addr == VECS[v].addr, "R2 op_addr", cap_addr, VECS[v].addr);
                wait_idle();
                check(last_len == int'(VECS[v].dur), "R9 busy width", last_len, VECS[v].dur);
            end else begin
                check(busy == 1'b0, "R7 no busy", busy, 0);
            end
        end

        // R6: select pulse with no clocks
        p0 = pulses;
        cs_n = 1'b0;
        repeat (8) @(posedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
        check(pulses == p0 && !busy, "R6 empty frame", pulses - p0, 0);

        // R10: frame completing while a block erase runs is dropped
        p0 = pulses;
        send({8'h50, 1'b0, 10'h002, 13'h0000}, 32);
        repeat (10) @(negedge clk);
        check(busy == 1'b1, "R10 erase running", busy, 1);
        send({8'h81, 1'b0, 13'h0777, 10'h000}, 32);
        repeat (10) @(negedge clk);
        check(busy == 1'b1, "R10 still busy", busy, 1);
        wait_idle();
        check(pulses - p0 == 1, "R10 single pulse", pulses - p0, 1);
        check(cap_addr == 13'h0010, "R10 addr unchanged", cap_addr, 13'h0010);
        check(last_len == TBE, "R10 width unchanged", last_len, TBE);

        // R10: after idle a frame is accepted again
        p0 = pulses;
        send({8'h81, 1'b0, 13'h0777, 10'h000}, 32);
        repeat (10) @(negedge clk);
        check(pulses - p0 == 1, "R10 accepted when idle", pulses - p0, 1);
        check(cap_addr == 13'h0777, "R4 addr", cap_addr, 13'h0777);
        wait_idle();

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule